// File: doc/BRIEF.md
# Conditional Block State Tracker

This block keeps the execution state for a short run of conditionally executed instructions that follows a block-start instruction. The run holds one to four instructions. Each instruction in the run uses either a base condition or its inverse. A load strobe captures the first condition and a then/else mask. A retire strobe advances the state once for each instruction that completes inside the run. The block presents the 4-bit condition of the next instruction, an in-run flag, and a pass/fail verdict computed from the N, Z, C and V flags.

The state has two parts: a base field of three bits and a shift field of `MAX_RUN+1` bits. The lowest set bit of the shift field marks how many instructions remain. The top bit of the shift field is the low bit of the next condition. On each retire the shift field moves left by one. When nothing would remain, the whole state clears.

The block also holds an instruction-set bit and a state-select bit. It offers a status-register read path whose conditional bits depend on debug mode. Status-register writes are ignored for every bit except the state-select bit.

Top module: `cond_run_tracker`

## Requirements
- R1: After reset the conditional state is all zero. `in_block_o` is 0, `next_cond_o` is 4'hE, `cond_pass_o` is 1, `invalid_o` is 0, the state-select bit is 0 and the instruction-set bit equals `T_RESET`.
- R2: A load with a non-zero mask sets the base field to `load_cond_i[3:1]` and the shift field to `{load_cond_i[0], load_mask_i}`. From the next cycle `in_block_o` is 1 and `next_cond_o` equals `load_cond_i`.
- R3: A load whose mask is zero is ignored, and the state stays as it was.
- R4: Each retire inside a run shifts the shift field left by one, with a 0 entering at the bottom, and leaves the base field unchanged. The run length is 4, 3, 2 or 1 when the lowest set mask bit is bit 0, 1, 2 or 3. The k-th later condition is `{base, mask[4-k]}`. After the last retire the whole state is zero.
- R5: When a load and a retire arrive in the same cycle, the load takes effect and the retire is dropped.
- R6: A retire while no run is active has no effect.
- R7: `cond_pass_o` follows the standard condition table for the flags `nzcv_i = {N,Z,C,V}`. Base codes 0 to 6 test Z, C, N, V, C and not Z, N equal to V, and not Z with N equal to V. A 1 in bit 0 of the condition inverts the result. Base code 7 always passes. `cond_pass_o` is 1 whenever no run is active.
- R8: `sr_rd_o` carries the state-select bit at bit 9 and the instruction-set bit at bit 8. Bits [7:0] carry `{base, shift field}` when `debug_i` is 1, and zero when `debug_i` is 0.
- R9: A status-register write changes only the state-select bit, taken from data bit 9. The conditional state and the instruction-set bit are unaffected.
- R10: `invalid_o` is 1 exactly when the low four shift bits are zero and either the base field is non-zero or the shift field's top bit is set. No sequence of port operations reaches such a state.
- R11: `isa_wr_i` loads `isa_val_i` into the instruction-set bit. No other input changes that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Block-start load strobe |
| load_cond_i | input | 4 | First condition of the run |
| load_mask_i | input | MAX_RUN | Then/else mask with its end marker |
| retire_i | input | 1 | One instruction completed |
| nzcv_i | input | 4 | Flags {N,Z,C,V} |
| debug_i | input | 1 | Debug mode for status reads |
| sr_wr_i | input | 1 | Status-register write strobe |
| sr_wr_data_i | input | MAX_RUN+6 | Status-register write data |
| isa_wr_i | input | 1 | Instruction-set bit write strobe |
| isa_val_i | input | 1 | New instruction-set bit value |
| next_cond_o | output | 4 | Condition of the next instruction |
| in_block_o | output | 1 | A run is active |
| cond_pass_o | output | 1 | Next instruction's condition holds |
| invalid_o | output | 1 | State encoding is invalid |
| sr_rd_o | output | MAX_RUN+6 | Status-register read view |
| t_o | output | 1 | Instruction-set bit |
| j_o | output | 1 | State-select bit |

## Verification
The bench builds the block with `MAX_RUN=4` and `T_RESET=1`. This configuration is small enough to sweep every first condition against every non-zero mask, which gives 240 runs. Each run is stepped to its end, and the condition, the in-run flag and both read views are checked at every position. For each condition code, all 16 flag combinations are applied to the pass output. Directed sequences cover a zero-mask load in the middle of a run, a load colliding with a retire, retires while idle, status writes and instruction-set writes.

// File: rtl/cond_run_pkg.sv
package cond_run_pkg;

    localparam int COND_W = 4;
    localparam int BASE_W = COND_W - 1;
    localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

    // Base pair codes (condition bits [3:1]); bit 0 inverts the test.
    typedef enum logic [BASE_W-1:0] {
        PAIR_ZERO  = 3'd0,
        PAIR_CARRY = 3'd1,
        PAIR_NEG   = 3'd2,
        PAIR_OVF   = 3'd3,
        PAIR_HIGH  = 3'd4,
        PAIR_SGE   = 3'd5,
        PAIR_SGT   = 3'd6,
        PAIR_ANY   = 3'd7
    } cond_pair_e;

    function automatic logic cond_holds(input logic [COND_W-1:0] code,
                                        input logic [3:0]        fl);
        logic n_f, z_f, c_f, v_f, raw;
        n_f = fl[3];
        z_f = fl[2];
        c_f = fl[1];
        v_f = fl[0];
        unique case (cond_pair_e'(code[COND_W-1:1]))
            PAIR_ZERO:  raw = z_f;
            PAIR_CARRY: raw = c_f;
            PAIR_NEG:   raw = n_f;
            PAIR_OVF:   raw = v_f;
            PAIR_HIGH:  raw = c_f & ~z_f;
            PAIR_SGE:   raw = (n_f == v_f);
            PAIR_SGT:   raw = ~z_f & (n_f == v_f);
            default:    raw = 1'b1;
        endcase
        if (cond_pair_e'(code[COND_W-1:1]) == PAIR_ANY) begin
            return 1'b1;
        end
        return raw ^ code[0];
    endfunction

endpackage

// File: rtl/cond_run_state.sv
module cond_run_state
    import cond_run_pkg::*;
#(
    parameter int   MAX_RUN = 4,
    parameter logic T_RESET = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [COND_W-1:0]     load_cond_i,
    input  logic [MAX_RUN-1:0]    load_mask_i,
    input  logic                  retire_i,
    input  logic                  j_wr_i,
    input  logic                  j_val_i,
    input  logic                  isa_wr_i,
    input  logic                  isa_val_i,
    output logic [BASE_W-1:0]     base_o,
    output logic [MAX_RUN:0]      field_o,
    output logic                  t_o,
    output logic                  j_o
);

    localparam int FIELD_W = MAX_RUN + 1;

    typedef struct packed {
        logic [BASE_W-1:0]  base;
        logic [FIELD_W-1:0] field;
        logic               t;
        logic               j;
    } run_state_t;

    run_state_t s_d, s_q;

    logic               active_q;
    logic [FIELD_W-1:0] shifted_d;

    always_comb begin
        s_d       = s_q;
        active_q  = |s_q.field[FIELD_W-2:0];
        shifted_d = {s_q.field[FIELD_W-2:0], 1'b0};

        if (load_i && (|load_mask_i)) begin
            s_d.base  = load_cond_i[COND_W-1:1];
            s_d.field = {load_cond_i[0], load_mask_i};
        end else if (retire_i && active_q) begin
            if (shifted_d[FIELD_W-2:0] == '0) begin
                s_d.base  = '0;
                s_d.field = '0;
            end else begin
                s_d.field = shifted_d;
            end
        end

        if (isa_wr_i) begin
            s_d.t = isa_val_i;
        end
        if (j_wr_i) begin
            s_d.j = j_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.base  <= '0;
            s_q.field <= '0;
            s_q.t     <= T_RESET;
            s_q.j     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign base_o  = s_q.base;
    assign field_o = s_q.field;
    assign t_o     = s_q.t;
    assign j_o     = s_q.j;

endmodule

// File: rtl/cond_run_decode.sv
module cond_run_decode
    import cond_run_pkg::*;
#(
    parameter int MAX_RUN = 4
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [MAX_RUN:0]  field_i,
    output logic              in_block_o,
    output logic              invalid_o,
    output logic [COND_W-1:0] next_cond_o
);

    localparam int FIELD_W = MAX_RUN + 1;

    logic low_clear;

    always_comb begin
        low_clear   = (field_i[FIELD_W-2:0] == '0);
        in_block_o  = ~low_clear;
        invalid_o   = low_clear & ((base_i != '0) | field_i[FIELD_W-1]);
        next_cond_o = in_block_o ? {base_i, field_i[FIELD_W-1]} : COND_ALWAYS;
    end

endmodule

// File: rtl/cond_flag_eval.sv
module cond_flag_eval
    import cond_run_pkg::*;
(
    input  logic [COND_W-1:0] cond_i,
    input  logic [3:0]        nzcv_i,
    input  logic              active_i,
    output logic              pass_o
);

    always_comb begin
        pass_o = active_i ? cond_holds(cond_i, nzcv_i) : 1'b1;
    end

endmodule

// File: rtl/cond_run_tracker.sv
module cond_run_tracker
    import cond_run_pkg::*;
#(
    parameter int   MAX_RUN = 4,
    parameter logic T_RESET = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [3:0]            load_cond_i,
    input  logic [MAX_RUN-1:0]    load_mask_i,
    input  logic                  retire_i,
    input  logic [3:0]            nzcv_i,
    input  logic                  debug_i,
    input  logic                  sr_wr_i,
    input  logic [MAX_RUN+5:0]    sr_wr_data_i,
    input  logic                  isa_wr_i,
    input  logic                  isa_val_i,
    output logic [3:0]            next_cond_o,
    output logic                  in_block_o,
    output logic                  cond_pass_o,
    output logic                  invalid_o,
    output logic [MAX_RUN+5:0]    sr_rd_o,
    output logic                  t_o,
    output logic                  j_o
);

    localparam int FIELD_W = MAX_RUN + 1;
    localparam int IT_W    = BASE_W + FIELD_W;
    localparam int SR_W    = IT_W + 2;

    logic [BASE_W-1:0]  base_q;
    logic [FIELD_W-1:0] field_q;
    logic               unused_sr_bits;

    // Only the top write bit (state select) is honoured.
    assign unused_sr_bits = ^sr_wr_data_i[SR_W-2:0];

    cond_run_state #(.MAX_RUN(MAX_RUN), .T_RESET(T_RESET)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_cond_i (load_cond_i),
        .load_mask_i (load_mask_i),
        .retire_i    (retire_i),
        .j_wr_i      (sr_wr_i),
        .j_val_i     (sr_wr_data_i[SR_W-1]),
        .isa_wr_i    (isa_wr_i),
        .isa_val_i   (isa_val_i),
        .base_o      (base_q),
        .field_o     (field_q),
        .t_o         (t_o),
        .j_o         (j_o)
    );

    cond_run_decode #(.MAX_RUN(MAX_RUN)) u_decode (
        .base_i      (base_q),
        .field_i     (field_q),
        .in_block_o  (in_block_o),
        .invalid_o   (invalid_o),
        .next_cond_o (next_cond_o)
    );

    cond_flag_eval u_eval (
        .cond_i   (next_cond_o),
        .nzcv_i   (nzcv_i),
        .active_i (in_block_o),
        .pass_o   (cond_pass_o)
    );

    always_comb begin
        sr_rd_o = {j_o, t_o, (debug_i ? {base_q, field_q} : {IT_W{1'b0}})};
    end

endmodule

// File: rtl/cond_run_checker.sv
module cond_run_checker #(
    parameter int MAX_RUN = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_i,
    input logic [3:0]         load_cond_i,
    input logic [MAX_RUN-1:0] load_mask_i,
    input logic               retire_i,
    input logic               debug_i,
    input logic               isa_wr_i,
    input logic [3:0]         next_cond_o,
    input logic               in_block_o,
    input logic               cond_pass_o,
    input logic               invalid_o,
    input logic [MAX_RUN+5:0] sr_rd_o,
    input logic               t_o
);

    localparam int IT_W = MAX_RUN + 4;

    p_load_sets_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (load_mask_i != '0)) |=> (in_block_o && next_cond_o == $past(load_cond_i)));

    p_zero_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (load_mask_i == '0) && !retire_i) |=> ($stable(next_cond_o) && $stable(in_block_o)));

    p_idle_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block_o && retire_i && !load_i) |=> !in_block_o);

    p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_block_o |-> cond_pass_o);

    p_read_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_i |-> (sr_rd_o[IT_W-1:0] == '0));

    p_never_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !invalid_o);

    p_isa_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_wr_i |=> $stable(t_o));

endmodule

bind cond_run_tracker cond_run_checker #(.MAX_RUN(MAX_RUN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_cond_i (load_cond_i),
    .load_mask_i (load_mask_i),
    .retire_i    (retire_i),
    .debug_i     (debug_i),
    .isa_wr_i    (isa_wr_i),
    .next_cond_o (next_cond_o),
    .in_block_o  (in_block_o),
    .cond_pass_o (cond_pass_o),
    .invalid_o   (invalid_o),
    .sr_rd_o     (sr_rd_o),
    .t_o         (t_o)
);

// File: tb/cond_run_tracker_test.sv
module cond_run_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       load_i;
    logic [3:0] load_cond_i;
    logic [3:0] load_mask_i;
    logic       retire_i;
    logic [3:0] nzcv_i;
    logic       debug_i;
    logic       sr_wr_i;
    logic [9:0] sr_wr_data_i;
    logic       isa_wr_i;
    logic       isa_val_i;
    logic [3:0] next_cond_o;
    logic       in_block_o;
    logic       cond_pass_o;
    logic       invalid_o;
    logic [9:0] sr_rd_o;
    logic       t_o;
    logic       j_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cond_run_tracker #(.MAX_RUN(4), .T_RESET(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_cond_i(load_cond_i),
        .load_mask_i(load_mask_i), .retire_i(retire_i), .nzcv_i(nzcv_i),
        .debug_i(debug_i), .sr_wr_i(sr_wr_i), .sr_wr_data_i(sr_wr_data_i),
        .isa_wr_i(isa_wr_i), .isa_val_i(isa_val_i), .next_cond_o(next_cond_o),
        .in_block_o(in_block_o), .cond_pass_o(cond_pass_o), .invalid_o(invalid_o),
        .sr_rd_o(sr_rd_o), .t_o(t_o), .j_o(j_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic exp_pass(input int code, input int fl);
        logic n, z, c, v;
        n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
        case (code)
            0:  return z;
            1:  return !z;
            2:  return c;
            3:  return !c;
            4:  return n;
            5:  return !n;
            6:  return v;
            7:  return !v;
            8:  return c && !z;
            9:  return !c || z;
            10: return n == v;
            11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic read_it(input logic dbg, output logic [7:0] val);
        debug_i = dbg;
        #1;
        val = sr_rd_o[7:0];
        debug_i = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; load_i = 0; load_cond_i = 0; load_mask_i = 0; retire_i = 0;
        nzcv_i = 0; debug_i = 0; sr_wr_i = 0; sr_wr_data_i = 0; isa_wr_i = 0; isa_val_i = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 in_block", in_block_o, 0);
        chk("R1 next_cond", next_cond_o, 4'hE);
        chk("R1 pass", cond_pass_o, 1);
        chk("R1 invalid", invalid_o, 0);
        chk("R1 t", t_o, 1);
        chk("R1 j", j_o, 0);
        read_it(1'b1, rd);
        chk("R1 state", rd, 8'h00);

        // R7 idle always passes
        for (int f = 0; f < 16; f++) begin
            nzcv_i = f[3:0]; #1;
            chk("R7 idle pass", cond_pass_o, 1);
        end

        // R2/R4/R7/R8/R10 sweep
        for (int c = 0; c < 16; c++) begin
            for (int m = 1; m < 16; m++) begin
                int len;
                len = (m & 1) ? 4 : (m & 2) ? 3 : (m & 4) ? 2 : 1;
                load_i = 1; load_cond_i = c[3:0]; load_mask_i = m[3:0];
                tick();
                load_i = 0;
                for (int k = 0; k < len; k++) begin
                    int bitv, fld;
                    bitv = (k == 0) ? (c & 1) : ((m >> (4 - k)) & 1);
                    fld  = ((((c & 1) << 4) | m) << k) & 31;
                    chk(k == 0 ? "R2 cond" : "R4 cond", next_cond_o, ((c >> 1) << 1) | bitv);
                    chk("R4 in_block", in_block_o, 1);
                    chk("R10 invalid", invalid_o, 0);
                    read_it(1'b1, rd);
                    chk("R8 debug view", rd, ((c >> 1) << 5) | fld);
                    read_it(1'b0, rd);
                    chk("R8 normal view", rd, 0);
                    if (k == 0 && m == 1) begin
                        for (int f = 0; f < 16; f++) begin
                            nzcv_i = f[3:0]; #1;
                            chk("R7 pass", cond_pass_o, exp_pass(c, f));
                        end
                    end
                    retire_i = 1;
                    tick();
                    retire_i = 0;
                end
                chk("R4 end", in_block_o, 0);
                chk("R4 end cond", next_cond_o, 4'hE);
                read_it(1'b1, rd);
                chk("R4 cleared", rd, 0);
            end
        end

        // R3 zero mask mid-run and idle
        load_i = 1; load_cond_i = 4'h5; load_mask_i = 4'b1010; tick();
        load_cond_i = 4'h3; load_mask_i = 4'b0000; tick();
        load_i = 0;
        chk("R3 cond kept", next_cond_o, 4'h5);
        read_it(1'b1, rd);
        chk("R3 state kept", rd, {3'b010, 5'b11010});

        // R5 load beats retire: cond 9 mask 1000 -> base 100, field 11000
        load_i = 1; retire_i = 1; load_cond_i = 4'h9; load_mask_i = 4'b1000; tick();
        load_i = 0; retire_i = 0;
        chk("R5 cond", next_cond_o, 4'h9);
        read_it(1'b1, rd);
        chk("R5 state", rd, 8'h98);
        retire_i = 1; tick(); retire_i = 0;
        chk("R5 one left", in_block_o, 0);

        load_i = 1; load_cond_i = 4'h0; load_mask_i = 4'b0000; tick(); load_i = 0;
        chk("R3 idle zero mask", in_block_o, 0);

        // R6 retire while idle
        retire_i = 1; tick(); tick(); tick(); retire_i = 0;
        chk("R6 idle", in_block_o, 0);
        read_it(1'b1, rd);
        chk("R6 state", rd, 0);

        // R9 status writes
        sr_wr_i = 1; sr_wr_data_i = 10'h3FF; tick(); sr_wr_i = 0;
        chk("R9 j set", j_o, 1);
        chk("R9 t kept", t_o, 1);
        chk("R9 idle kept", in_block_o, 0);
        load_i = 1; load_cond_i = 4'hB; load_mask_i = 4'b0100; tick(); load_i = 0;
        sr_wr_i = 1; sr_wr_data_i = 10'h000; tick(); sr_wr_i = 0;
        chk("R9 j clear", j_o, 0);
        chk("R9 t kept", t_o, 1);
        read_it(1'b1, rd);
        chk("R9 state kept", rd, {3'b101, 5'b10100});
        chk("R8 top bits", sr_rd_o[9:8], 2'b01);

        // R11 instruction-set bit
        isa_wr_i = 1; isa_val_i = 0; tick(); isa_wr_i = 0;
        chk("R11 t clear", t_o, 0);
        chk("R8 t bit view", sr_rd_o[8], 0);
        chk("R11 state kept", next_cond_o, 4'hB);
        isa_wr_i = 1; isa_val_i = 1; tick(); isa_wr_i = 0;
        chk("R11 t set", t_o, 1);

        done = 1;
        finish_run();
    end

endmodule